// File: doc/BRIEF.md
# Write-Protected GPIO Bank Register Block

This block is a word-addressed register file for one to eight banks of 32 general-purpose pins. Each pin has a direction control word. Each bank has an output latch, a synchronized view of the pad inputs, a write-one-to-set port, a write-one-to-clear port and a per-pin write-protect mask. The block drives the pad output and output-enable vectors from its latches. It samples the pad input vector through a two-stage synchronizer.

Software changes outputs by writing ones to the set or clear port, so it never needs a read-modify-write cycle. A set bit in a bank's protect mask freezes that pin's direction and output. The mask can be rewritten only by the write that comes immediately after a key write.

The key sequence is a two-state machine. `PW_IDLE` moves to `PW_ARMED` when the key value is written to the key register (transition *arm*). In `PW_ARMED`, a further write of the key keeps the state (*re-arm*). Any other write returns it to `PW_IDLE` (*disarm*). A write to a protect mask that arrives in `PW_ARMED` is applied and also disarms the machine (*consume*). Reads never change the state.

Top module: `gpio_lockbank_top`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all 0), every output latch is 0 (`pad_out` all 0), and every implemented bank's protect mask reads 0xFFFFFFFF.
- R2: The word addresses are as follows. Output status for bank b is at 0x000+b and input status at 0x008+b. The set port is at 0x010+b and the clear port at 0x018+b. The pin control word for pin p is at 0x040+p. The protect mask for bank b is at 0x140+b and the key register is at 0x148. Pin p belongs to bank p>>5, bit p&31. The set and clear ports, and any unmapped address, read as 0.
- R3: Bit 0 of a pin control word selects the direction: 1 means input and 0 means output. A control word reads back as {31'b0, direction}. `pad_oe` for that pin is the inverse of the direction bit, and `pad_out` always shows the output latch.
- R4: Writing the set port sets the latch bits where the write data has ones. Bits where the data is 0 are left unchanged.
- R5: Writing the clear port clears the latch bits where the write data has ones. Bits where the data is 0 are left unchanged.
- R6: Output status reads return the output latch. Input status reads return the pad level after two clock edges: it is not yet visible after one edge and is visible after the second.
- R7: A protect-mask write takes effect only when the previous write was the key value 0x00A5A501 to the key register. The key is consumed, so a second mask write needs a new key write.
- R8: Any write that comes between the key write and the mask write disarms the key, as does a key write with a wrong value. Reads between the two writes do not disarm it.
- R9: While a pin's protect bit is 1, writes to its control word and to its bit in the set and clear ports are ignored. Unprotected pins in the same bank still respond, and reads are unaffected.
- R10: Addresses of banks at or above `NUM_BANKS` read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Word address |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_BANKS*32 | Pad input levels, asynchronous |
| pad_out | output | NUM_BANKS*32 | Output latch values |
| pad_oe | output | NUM_BANKS*32 | Output enable, 1 for pins set as outputs |

## Verification
The assertions assume that `bus_we` is a single-cycle strobe with a stable address and data during that cycle. They also assume that reset is applied before the first access, so every `$past` value comes from reset state. The bench drives every bus access at the falling edge and holds each write for exactly one cycle. It changes `pad_in` only at falling edges, so the two-edge latency of the synchronizer can be counted exactly. Reads are issued only with the strobe low, which lets the bench test that reads do not disarm the key.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
    localparam int ADDR_W    = 9;
    localparam int BANK_W    = 32;
    localparam int BIT_IDX_W = $clog2(BANK_W);
    localparam int MAX_BANKS = 8;

    // word-address groups (addr[8:3]) and pin-control window
    localparam logic [5:0] GRP_OUT  = 6'h00;
    localparam logic [5:0] GRP_IN   = 6'h01;
    localparam logic [5:0] GRP_SET  = 6'h02;
    localparam logic [5:0] GRP_CLR  = 6'h03;
    localparam logic [5:0] GRP_LOCK = 6'h28;
    localparam logic [ADDR_W-1:0] ADDR_KEY   = 9'h148;
    localparam logic [ADDR_W-1:0] CTL_FIRST  = 9'h040;
    localparam logic [ADDR_W-1:0] CTL_LAST   = 9'h13F;
    localparam logic [31:0]       UNLOCK_KEY = 32'h00A5_A501;

    typedef enum logic {PW_IDLE, PW_ARMED} pw_state_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/gpio_pw_fsm.sv
module gpio_pw_fsm
    import gpio_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_we,
    input  logic key_hit,   // write address is key register and data matches
    output logic armed
);
    pw_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE:  if (bus_we && key_hit) state_d = PW_ARMED;               // arm
            PW_ARMED: if (bus_we) state_d = key_hit ? PW_ARMED : PW_IDLE;      // re-arm / disarm / consume
            default:  state_d = PW_IDLE;
        endcase
    end

    always_comb begin
        armed = (state_q == PW_ARMED);
    end

    assert_arm_needs_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(bus_we && key_hit));
    assert_disarm_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed) |-> $past(bus_we));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_we,
    input  logic [BIT_IDX_W-1:0] ctl_bit,
    input  logic                 ctl_dir,
    input  logic                 set_we,
    input  logic                 clr_we,
    input  logic                 lock_we,
    input  logic [BANK_W-1:0]    wdata,
    output logic [BANK_W-1:0]    dir_q,
    output logic [BANK_W-1:0]    out_q,
    output logic [BANK_W-1:0]    lock_q
);
    logic [BANK_W-1:0] open_bits;
    assign open_bits = wdata & ~lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            out_q  <= '0;
            lock_q <= '1;
        end else begin
            if (lock_we) lock_q <= wdata;
            if (ctl_we && !lock_q[ctl_bit]) dir_q[ctl_bit] <= ctl_dir;
            if (set_we) out_q <= out_q | open_bits;
            else if (clr_we) out_q <= out_q & ~open_bits;
        end
    end

    assert_locked_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q ^ $past(dir_q)) & $past(lock_q)) == '0);
    assert_locked_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_q ^ $past(out_q)) & $past(lock_q)) == '0);
    assert_set_no_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_we) |-> ((out_q & $past(out_q)) == $past(out_q)));
endmodule

// File: rtl/gpio_lockbank_top.sv
module gpio_lockbank_top
    import gpio_regs_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [8:0]                  bus_addr,
    input  logic                        bus_we,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] pad_in,
    output logic [NUM_BANKS*BANK_W-1:0] pad_out,
    output logic [NUM_BANKS*BANK_W-1:0] pad_oe
);
    localparam int NPINS = NUM_BANKS * BANK_W;

    logic [5:0]                 grp;
    logic [2:0]                 bidx;
    logic                       is_ctl;
    logic [ADDR_W-1:0]          ctl_pin;
    logic [2:0]                 cbank;
    logic [BIT_IDX_W-1:0]       cbit;
    logic                       key_hit, armed;
    logic [NPINS-1:0]           in_sync;
    logic [NUM_BANKS-1:0][31:0] dir_q, out_q, lock_q, in_q;
    logic [NUM_BANKS-1:0]       ctl_we, set_we, clr_we, lock_we;

    assign grp     = bus_addr[8:3];
    assign bidx    = bus_addr[2:0];
    assign is_ctl  = (bus_addr >= CTL_FIRST) && (bus_addr <= CTL_LAST);
    assign ctl_pin = bus_addr - CTL_FIRST;
    assign cbank   = ctl_pin[7:5];
    assign cbit    = ctl_pin[4:0];
    assign key_hit = (bus_addr == ADDR_KEY) && (bus_wdata == UNLOCK_KEY);

    gpio_pw_fsm u_pw (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .key_hit(key_hit), .armed(armed)
    );

    gpio_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pad_in), .q_sync(in_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign ctl_we[b]  = bus_we && is_ctl && (cbank == 3'(b));
        assign set_we[b]  = bus_we && (grp == GRP_SET)  && (bidx == 3'(b));
        assign clr_we[b]  = bus_we && (grp == GRP_CLR)  && (bidx == 3'(b));
        assign lock_we[b] = bus_we && armed && (grp == GRP_LOCK) && (bidx == 3'(b));
        assign in_q[b]    = in_sync[b*BANK_W +: BANK_W];

        gpio_bank_regs u_regs (
            .clk(clk), .rst_n(rst_n),
            .ctl_we(ctl_we[b]), .ctl_bit(cbit), .ctl_dir(bus_wdata[0]),
            .set_we(set_we[b]), .clr_we(clr_we[b]), .lock_we(lock_we[b]),
            .wdata(bus_wdata),
            .dir_q(dir_q[b]), .out_q(out_q[b]), .lock_q(lock_q[b])
        );

        assign pad_out[b*BANK_W +: BANK_W] = out_q[b];
        assign pad_oe[b*BANK_W +: BANK_W]  = ~dir_q[b];

        assert_lock_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_q[b] != $past(lock_q[b])) |->
                $past(armed && bus_we && bus_addr == (9'h140 + 9'(b))));
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (is_ctl && cbank == 3'(b))              bus_rdata = {31'b0, dir_q[b][cbit]};
            else if (grp == GRP_OUT  && bidx == 3'(b)) bus_rdata = out_q[b];
            else if (grp == GRP_IN   && bidx == 3'(b)) bus_rdata = in_q[b];
            else if (grp == GRP_LOCK && bidx == 3'(b)) bus_rdata = lock_q[b];
        end
    end

    assert_bank_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_we, set_we, clr_we, lock_we}));
endmodule

// File: tb/tb_gpio_lockbank_top.sv
module tb_gpio_lockbank_top;
    localparam int NB = 2;
    localparam logic [31:0] KEY = 32'h00A5_A501;

    logic            clk = 0;
    logic            rst_n = 0;
    logic [8:0]      bus_addr = '0;
    logic            bus_we = 0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NB*32-1:0] pad_in = '0;
    logic [NB*32-1:0] pad_out, pad_oe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gpio_lockbank_top #(.NUM_BANKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] v);
        bus_we = 0; bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 pad_oe", pad_oe[31:0] | pad_oe[63:32], 32'h0);
        chk("R1 pad_out", pad_out[31:0] | pad_out[63:32], 32'h0);
        rd(9'h140, v); chk("R1 lock b0", v, 32'hFFFF_FFFF);
        rd(9'h141, v); chk("R1 lock b1", v, 32'hFFFF_FFFF);
        rd(9'h045, v); chk("R1 ctl pin5 input", v, 32'h1);
        rd(9'h000, v); chk("R1 out status", v, 32'h0);
    endtask

    task automatic t_locked();
        logic [31:0] v;
        wr(9'h043, 32'h0);
        rd(9'h043, v); chk("R9 locked ctl ignored", v, 32'h1);
        chk("R9 locked oe", {31'b0, pad_oe[3]}, 32'h0);
        wr(9'h010, 32'hFFFF_FFFF);
        rd(9'h000, v); chk("R9 locked set ignored", v, 32'h0);
    endtask

    task automatic t_unlock();
        logic [31:0] v;
        wr(9'h148, KEY);
        wr(9'h140, 32'h0);
        rd(9'h140, v); chk("R7 unlock b0", v, 32'h0);
        rd(9'h141, v); chk("R7 b1 untouched", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_dir();
        logic [31:0] v;
        wr(9'h043, 32'h0);
        rd(9'h043, v); chk("R3 pin3 output", v, 32'h0);
        chk("R3 pin3 oe", {31'b0, pad_oe[3]}, 32'h1);
        wr(9'h068, 32'h0);
        rd(9'h068, v); chk("R9 pin40 locked", v, 32'h1);
        chk("R3 pin40 oe", {31'b0, pad_oe[40]}, 32'h0);
    endtask

    task automatic t_setclr();
        logic [31:0] v;
        wr(9'h010, 32'h9);
        rd(9'h000, v); chk("R4 set 9", v, 32'h9);
        wr(9'h010, 32'h2);
        rd(9'h000, v); chk("R4 zeros keep", v, 32'hB);
        wr(9'h018, 32'h1);
        rd(9'h000, v); chk("R5 clear bit0", v, 32'hA);
        chk("R3 pad_out", pad_out[31:0], 32'hA);
        rd(9'h010, v); chk("R2 set port reads 0", v, 32'h0);
        rd(9'h150, v); chk("R2 unmapped reads 0", v, 32'h0);
    endtask

    task automatic t_input();
        logic [31:0] v;
        @(negedge clk);
        pad_in[33] = 1'b1;
        rd(9'h009, v); chk("R6 in before edge", v, 32'h0);
        @(negedge clk);
        rd(9'h009, v); chk("R6 in after 1 edge", v, 32'h0);
        @(negedge clk);
        rd(9'h009, v); chk("R6 in after 2 edges", v, 32'h2);
        rd(9'h008, v); chk("R6 bank0 in", v, 32'h0);
    endtask

    task automatic t_password();
        logic [31:0] v;
        wr(9'h148, KEY);
        wr(9'h010, 32'h0);
        wr(9'h140, 32'hFFFF_FFFF);
        rd(9'h140, v); chk("R8 intervening write disarms", v, 32'h0);
        wr(9'h148, 32'h00A5_A500);
        wr(9'h140, 32'hFFFF_FFFF);
        rd(9'h140, v); chk("R8 wrong key", v, 32'h0);
        wr(9'h148, KEY);
        rd(9'h000, v);
        wr(9'h140, 32'h2);
        rd(9'h140, v); chk("R8 read keeps armed", v, 32'h2);
        wr(9'h010, 32'h5);
        rd(9'h000, v); chk("R9 set partial", v, 32'hF);
        wr(9'h018, 32'hF);
        rd(9'h000, v); chk("R9 clear partial", v, 32'h2);
        wr(9'h041, 32'h0);
        rd(9'h041, v); chk("R9 pin1 ctl locked", v, 32'h1);
        wr(9'h043, 32'h1);
        rd(9'h043, v); chk("R9 pin3 ctl open", v, 32'h1);
        wr(9'h148, KEY);
        wr(9'h141, 32'h0);
        rd(9'h141, v); chk("R7 b1 unlock", v, 32'h0);
        wr(9'h141, 32'hFFFF_FFFF);
        rd(9'h141, v); chk("R7 key consumed", v, 32'h0);
    endtask

    task automatic t_bank_limit();
        logic [31:0] v;
        rd(9'h142, v); chk("R10 lock b2 reads 0", v, 32'h0);
        rd(9'h086, v); chk("R10 ctl pin70 reads 0", v, 32'h0);
        wr(9'h148, KEY);
        wr(9'h142, 32'h0);
        wr(9'h012, 32'hFFFF_FFFF);
        rd(9'h002, v); chk("R10 out b2 reads 0", v, 32'h0);
        chk("R10 pad_out unchanged", pad_out[31:0], 32'h2);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_locked();
        t_unlock();
        t_dir();
        t_setclr();
        t_input();
        t_password();
        t_bank_limit();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule